// File: doc/BRIEF.md
# Compact 8-bit Instruction Sequencer

This block is a multi-cycle fetch, decode and execute engine for a small subset of a classic 8-bit console processor's instruction set. It holds an accumulator, a flag register, the H and L pair, a 16-bit program counter, a 16-bit stack pointer and an interrupt enable bit. It fetches an opcode byte, then any little-endian operand bytes. It carries out loads, an accumulator increment, absolute and register-indirect jumps, calls and interrupt disable. The stack grows toward lower addresses.

The core drives a single byte-wide bus as master. It performs at most one access per clock cycle. Read data must be valid combinationally in the same cycle as the read strobe, and it is captured at the next rising edge. A write takes effect at the rising edge of the cycle in which the write enable is high. An opcode that the core does not know stops it for good: the `halted` output rises and the bus goes idle until reset. So does any second byte after the 0xCB prefix. The architectural registers come out on observation ports for integration and debug.

Top module: `cpu8_seq_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the core loads PC=0x0100, SP=0xDFFF, A=0x00, F=0x00, interrupt enable=IME_RESET (1 by default) and clears `halted`. The first opcode fetch reads address 0x0100.
- R2: Opcode 0x00 takes one cycle and only adds 1 to PC.
- R3: Opcode 0x21 takes three cycles. L gets the first operand byte, H gets the second, and PC advances by 3.
- R4: Opcode 0x31 takes three cycles. It loads SP with the operand (low byte first) and advances PC by 3.
- R5: Opcode 0x3C takes one cycle and adds 1 to A modulo 256. In F, bit 7 (zero) is set exactly when the result is 0x00, bit 6 (subtract) is cleared, bit 5 (half carry) is set exactly when the old low nibble was 0xF, and bits 4..0 are unchanged.
- R6: Opcode 0xC3 takes three cycles and loads PC with the operand, low byte first.
- R7: Opcode 0xCD takes five cycles. It pushes the address that follows its two operand bytes, leaves SP lowered by 2, and loads PC with the operand.
- R8: Each pushed byte is written at SP-1, and SP then holds that address. The high byte of a 16-bit value is written first and the low byte second, so the low byte ends at the lower address.
- R9: Opcode 0xE9 takes one cycle and loads PC with {H, L}.
- R10: Opcode 0xF3 takes one cycle, clears the interrupt enable and adds 1 to PC.
- R11: Any opcode other than those listed above raises `halted` after its fetch cycle. Opcode 0xCB fetches one more byte, adding 1 to PC again, and then raises `halted` whatever that byte is.
- R12: Once `halted` is high it stays high. `bus_re` and `bus_we` stay low, and PC, SP, A and F hold their values until reset.
- R13: `bus_re` and `bus_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | output | 16 | Byte address of the current access |
| bus_re | output | 1 | Read strobe; data is sampled at the next rising edge |
| bus_we | output | 1 | Write strobe; `bus_wdata` is stored at the next rising edge |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the same cycle as `bus_re` |
| halted | output | 1 | High after an invalid or prefixed opcode stops the core |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| a_o | output | 8 | Accumulator |
| f_o | output | 8 | Flag register (bit 7 zero, bit 6 subtract, bit 5 half carry, bit 4 carry) |
| h_o | output | 8 | High byte of the HL pair |
| l_o | output | 8 | Low byte of the HL pair |
| ime_o | output | 1 | Interrupt master enable |

## Verification
The bench builds the core with its default parameters: reset vector 0x0100, stack top 0xDFFF and the interrupt enable set out of reset. Because the enable starts high, clearing it with 0xF3 shows up as a change at the port. Because the stack top sits at the end of a page, the bench's 4 KiB memory can alias the stack bytes without overlapping the program area. A run of 256 back-to-back increments at 0x0100 brings the nibble carry at 0x0F and the wrap to zero at 0xFF within reach, and each instruction is timed by counting its cycles to the architectural change.

// File: rtl/cpu8_pkg.sv
// cpu8_pkg: shared opcode values, instruction classes, sequencer states
// and flag bit positions for the 8-bit instruction sequencer.
// Assumes byte-wide data and 16-bit addresses throughout.
package cpu8_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int NIB_W  = DATA_W / 2;

    // Flag bit positions inside F
    localparam int FLG_Z = 7;
    localparam int FLG_N = 6;
    localparam int FLG_H = 5;

    // Opcode values
    localparam logic [DATA_W-1:0] OPC_NOP    = 8'h00;
    localparam logic [DATA_W-1:0] OPC_LDHL   = 8'h21;
    localparam logic [DATA_W-1:0] OPC_LDSP   = 8'h31;
    localparam logic [DATA_W-1:0] OPC_INCA   = 8'h3C;
    localparam logic [DATA_W-1:0] OPC_JP     = 8'hC3;
    localparam logic [DATA_W-1:0] OPC_PREFIX = 8'hCB;
    localparam logic [DATA_W-1:0] OPC_CALL   = 8'hCD;
    localparam logic [DATA_W-1:0] OPC_JPHL   = 8'hE9;
    localparam logic [DATA_W-1:0] OPC_DI     = 8'hF3;

    typedef enum logic [3:0] {
        CLS_NOP,
        CLS_LDHL,
        CLS_LDSP,
        CLS_INCA,
        CLS_JP,
        CLS_CALL,
        CLS_JPHL,
        CLS_DI,
        CLS_PREFIX,
        CLS_BAD
    } op_class_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_PFX,
        ST_IMM_LO,
        ST_IMM_HI,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_HALT
    } seq_state_t;

endpackage

// File: rtl/cpu8_decode.sv
// cpu8_decode: maps a fetched opcode byte onto an instruction class.
// Purely combinational; every value not in the supported set maps to CLS_BAD.
module cpu8_decode
    import cpu8_pkg::*;
(
    input  logic [DATA_W-1:0] opcode,
    output op_class_t         op_class,
    output logic              needs_imm
);

    // Classify the opcode byte
    always_comb begin
        unique case (opcode)
            OPC_NOP:    op_class = CLS_NOP;
            OPC_LDHL:   op_class = CLS_LDHL;
            OPC_LDSP:   op_class = CLS_LDSP;
            OPC_INCA:   op_class = CLS_INCA;
            OPC_JP:     op_class = CLS_JP;
            OPC_CALL:   op_class = CLS_CALL;
            OPC_JPHL:   op_class = CLS_JPHL;
            OPC_DI:     op_class = CLS_DI;
            OPC_PREFIX: op_class = CLS_PREFIX;
            default:    op_class = CLS_BAD;
        endcase
    end

    // Flag classes that carry a 16-bit operand
    always_comb begin
        needs_imm = (op_class == CLS_LDHL) || (op_class == CLS_LDSP) ||
                    (op_class == CLS_JP)   || (op_class == CLS_CALL);
    end

endmodule

// File: rtl/cpu8_inc_unit.sv
// cpu8_inc_unit: accumulator increment with flag update.
// Z follows a zero result, N is cleared, H follows the low-nibble carry,
// and all other flag bits pass through unchanged.
module cpu8_inc_unit
    import cpu8_pkg::*;
(
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] flags_in,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] flags_out
);

    // Compute sum and the new flag byte
    always_comb begin
        acc_out          = acc_in + {{(DATA_W-1){1'b0}}, 1'b1};
        flags_out        = flags_in;
        flags_out[FLG_Z] = (acc_out == '0);
        flags_out[FLG_N] = 1'b0;
        flags_out[FLG_H] = (acc_in[NIB_W-1:0] == {NIB_W{1'b1}});
    end

endmodule

// File: rtl/cpu8_seq_core.sv
// cpu8_seq_core: multi-cycle sequencer for the supported opcode subset.
// Assumes a bus whose read data is valid in the same cycle as bus_re.
// One bus access per cycle; stops permanently on an unknown opcode.
module cpu8_seq_core
    import cpu8_pkg::*;
#(
    parameter logic [15:0] RESET_PC  = 16'h0100,
    parameter logic [15:0] RESET_SP  = 16'hDFFF,
    parameter bit          IME_RESET = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] bus_addr,
    output logic        bus_re,
    output logic        bus_we,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata,
    output logic        halted,
    output logic [15:0] pc_o,
    output logic [15:0] sp_o,
    output logic [7:0]  a_o,
    output logic [7:0]  f_o,
    output logic [7:0]  h_o,
    output logic [7:0]  l_o,
    output logic        ime_o
);

    localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

    seq_state_t        state_q;
    op_class_t         op_q;
    op_class_t         dec_class;
    logic              dec_imm;
    logic [ADDR_W-1:0] pc_q, sp_q, tgt_q;
    logic [DATA_W-1:0] a_q, f_q, h_q, l_q, lo_q;
    logic              ime_q;
    logic [DATA_W-1:0] inc_a, inc_f;
    logic [ADDR_W-1:0] imm16;

    cpu8_decode u_decode (
        .opcode    (bus_rdata),
        .op_class  (dec_class),
        .needs_imm (dec_imm)
    );

    cpu8_inc_unit u_inc (
        .acc_in    (a_q),
        .flags_in  (f_q),
        .acc_out   (inc_a),
        .flags_out (inc_f)
    );

    // Assemble the little-endian operand from the latched low byte
    always_comb imm16 = {bus_rdata, lo_q};

    // Drive the bus from the current state
    always_comb begin
        bus_re    = (state_q == ST_FETCH) || (state_q == ST_PFX) ||
                    (state_q == ST_IMM_LO) || (state_q == ST_IMM_HI);
        bus_we    = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO);
        bus_addr  = bus_we ? (sp_q - ONE_A) : pc_q;
        bus_wdata = (state_q == ST_PUSH_HI) ? pc_q[ADDR_W-1:DATA_W] : pc_q[DATA_W-1:0];
    end

    // Sequencer and architectural register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            op_q    <= CLS_NOP;
            pc_q    <= RESET_PC;
            sp_q    <= RESET_SP;
            tgt_q   <= '0;
            a_q     <= '0;
            f_q     <= '0;
            h_q     <= '0;
            l_q     <= '0;
            lo_q    <= '0;
            ime_q   <= IME_RESET;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    pc_q <= pc_q + ONE_A;
                    op_q <= dec_class;
                    if (dec_imm) begin
                        state_q <= ST_IMM_LO;
                    end else begin
                        unique case (dec_class)
                            CLS_INCA: begin
                                a_q <= inc_a;
                                f_q <= inc_f;
                            end
                            CLS_JPHL:   pc_q    <= {h_q, l_q};
                            CLS_DI:     ime_q   <= 1'b0;
                            CLS_PREFIX: state_q <= ST_PFX;
                            CLS_BAD:    state_q <= ST_HALT;
                            default:    ;
                        endcase
                    end
                end
                ST_PFX: begin
                    pc_q    <= pc_q + ONE_A;
                    state_q <= ST_HALT;
                end
                ST_IMM_LO: begin
                    lo_q    <= bus_rdata;
                    pc_q    <= pc_q + ONE_A;
                    state_q <= ST_IMM_HI;
                end
                ST_IMM_HI: begin
                    pc_q    <= pc_q + ONE_A;
                    state_q <= ST_FETCH;
                    unique case (op_q)
                        CLS_LDHL: begin
                            h_q <= bus_rdata;
                            l_q <= lo_q;
                        end
                        CLS_LDSP: sp_q <= imm16;
                        CLS_JP:   pc_q <= imm16;
                        CLS_CALL: begin
                            tgt_q   <= imm16;
                            state_q <= ST_PUSH_HI;
                        end
                        default:  ;
                    endcase
                end
                ST_PUSH_HI: begin
                    sp_q    <= sp_q - ONE_A;
                    state_q <= ST_PUSH_LO;
                end
                ST_PUSH_LO: begin
                    sp_q    <= sp_q - ONE_A;
                    pc_q    <= tgt_q;
                    state_q <= ST_FETCH;
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    // Expose architectural state
    always_comb begin
        halted = (state_q == ST_HALT);
        pc_o   = pc_q;
        sp_o   = sp_q;
        a_o    = a_q;
        f_o    = f_q;
        h_o    = h_q;
        l_o    = l_q;
        ime_o  = ime_q;
    end

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_re && bus_we)); // R13

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && pc_q == $past(pc_q) && sp_q == $past(sp_q))); // R12

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!bus_re && !bus_we)); // R12

    AST_PUSH_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (sp_q == $past(sp_q) - ONE_A)); // R8

    AST_INC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && bus_rdata == OPC_INCA) |=>
        (a_q == $past(a_q) + 8'd1 && !f_q[FLG_N] && f_q[4:0] == $past(f_q[4:0]))); // R5

    AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && bus_rdata == OPC_DI) |=> !ime_q); // R10

endmodule

// File: tb/cpu8_seq_core_tb_top.sv
`timescale 1ns/1ps
module cpu8_seq_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr;
    logic        bus_re, bus_we, halted, ime_o;
    logic [7:0]  bus_wdata, bus_rdata, a_o, f_o, h_o, l_o;
    logic [15:0] pc_o, sp_o;

    logic [7:0]  mem [0:4095];
    int          wr_cnt;
    logic [15:0] wr_addr [0:1];
    logic [7:0]  wr_data [0:1];
    int          clash_cnt = 0;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cpu8_seq_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_re(bus_re), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .halted(halted), .pc_o(pc_o), .sp_o(sp_o), .a_o(a_o), .f_o(f_o),
        .h_o(h_o), .l_o(l_o), .ime_o(ime_o)
    );

    assign bus_rdata = mem[bus_addr[11:0]];

    // Memory model: store writes and log the first two of each run
    always @(posedge clk) begin
        if (bus_we) begin
            mem[bus_addr[11:0]] <= bus_wdata;
            if (wr_cnt < 2) begin
                wr_addr[wr_cnt] <= bus_addr;
                wr_data[wr_cnt] <= bus_wdata;
            end
            wr_cnt <= wr_cnt + 1;
        end
    end

    // Count cycles where read and write collide (R13)
    always @(negedge clk) if (rst_n && bus_re && bus_we) clash_cnt++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] bytes [], input int base);
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        foreach (bytes[i]) mem[(base + i) & 12'hFFF] = bytes[i];
    endtask

    task automatic restart();
        rst_n = 1'b0;
        wr_cnt = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        load('{8'h00}, 16'h0100);
        restart();
        check(pc_o == 16'h0100, "R1 pc", pc_o, 16'h0100);
        check(sp_o == 16'hDFFF, "R1 sp", sp_o, 16'hDFFF);
        check(a_o == 8'h00 && f_o == 8'h00, "R1 a/f", {a_o, f_o}, 0);
        check(ime_o && !halted, "R1 ime/halted", {ime_o, halted}, 2);
        check(bus_re && bus_addr == 16'h0100, "R1 first fetch", bus_addr, 16'h0100);
    endtask

    task automatic t_nop();
        load('{8'h00, 8'h00}, 16'h0100);
        restart();
        run(1);
        check(pc_o == 16'h0101, "R2 nop pc", pc_o, 16'h0101);
    endtask

    task automatic t_ldhl();
        load('{8'h21, 8'h34, 8'h12}, 16'h0100);
        restart();
        run(2);
        check(h_o == 8'h00, "R3 not before cycle 3", h_o, 0);
        run(1);
        check(h_o == 8'h12 && l_o == 8'h34, "R3 hl", {h_o, l_o}, 16'h1234);
        check(pc_o == 16'h0103, "R3 pc", pc_o, 16'h0103);
    endtask

    task automatic t_ldsp();
        load('{8'h31, 8'hFF, 8'hCF}, 16'h0100);
        restart();
        run(3);
        check(sp_o == 16'hCFFF, "R4 sp", sp_o, 16'hCFFF);
        check(pc_o == 16'h0103, "R4 pc", pc_o, 16'h0103);
    endtask

    task automatic t_inc();
        logic [7:0] prog [];
        prog = new[256];
        foreach (prog[i]) prog[i] = 8'h3C;
        load(prog, 16'h0100);
        restart();
        run(1);
        check(a_o == 8'h01 && f_o == 8'h00, "R5 first inc", {a_o, f_o}, 16'h0100);
        run(15);
        check(a_o == 8'h10 && f_o == 8'h20, "R5 nibble carry", {a_o, f_o}, 16'h1020);
        run(1);
        check(a_o == 8'h11 && f_o == 8'h00, "R5 H clears", {a_o, f_o}, 16'h1100);
        run(239);
        check(a_o == 8'h00 && f_o == 8'hA0, "R5 wrap zero", {a_o, f_o}, 16'h00A0);
        check(pc_o == 16'h0200, "R5 pc", pc_o, 16'h0200);
    endtask

    task automatic t_jp();
        load('{8'hC3, 8'h50, 8'h02}, 16'h0100);
        restart();
        run(3);
        check(pc_o == 16'h0250, "R6 jump", pc_o, 16'h0250);
    endtask

    task automatic t_call();
        load('{8'hCD, 8'h4C, 8'h04}, 16'h0100);
        restart();
        run(4);
        check(pc_o == 16'h0103, "R7 not yet jumped", pc_o, 16'h0103);
        run(1);
        check(pc_o == 16'h044C, "R7 target", pc_o, 16'h044C);
        check(sp_o == 16'hDFFD, "R7 sp", sp_o, 16'hDFFD);
        check(wr_cnt == 2, "R8 write count", wr_cnt, 2);
        check(wr_addr[0] == 16'hDFFE && wr_data[0] == 8'h01, "R8 first push hi",
              {wr_addr[0], wr_data[0]}, 24'hDFFE01);
        check(wr_addr[1] == 16'hDFFD && wr_data[1] == 8'h03, "R8 second push lo",
              {wr_addr[1], wr_data[1]}, 24'hDFFD03);
    endtask

    task automatic t_jphl();
        load('{8'h21, 8'h34, 8'h02, 8'hE9}, 16'h0100);
        restart();
        run(4);
        check(pc_o == 16'h0234, "R9 jump hl", pc_o, 16'h0234);
    endtask

    task automatic t_di();
        load('{8'hF3}, 16'h0100);
        restart();
        run(1);
        check(!ime_o && pc_o == 16'h0101, "R10 di", {ime_o, pc_o}, 16'h0101);
    endtask

    task automatic t_bad();
        int acc;
        load('{8'hD3, 8'h00}, 16'h0100);
        restart();
        run(1);
        check(halted && pc_o == 16'h0101, "R11 unknown halts", {halted, pc_o}, 17'h10101);
        acc = 0;
        for (int i = 0; i < 6; i++) begin
            if (bus_re || bus_we) acc++;
            run(1);
        end
        check(acc == 0, "R12 bus idle", acc, 0);
        check(halted && pc_o == 16'h0101 && sp_o == 16'hDFFF, "R12 state held", pc_o, 16'h0101);
    endtask

    task automatic t_prefix();
        load('{8'hCB, 8'h37, 8'h00}, 16'h0100);
        restart();
        run(1);
        check(!halted, "R11 prefix not yet halted", halted, 0);
        run(1);
        check(halted && pc_o == 16'h0102, "R11 prefix halts", {halted, pc_o}, 17'h10102);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_nop();
        t_ldhl();
        t_ldsp();
        t_inc();
        t_jp();
        t_call();
        t_jphl();
        t_di();
        t_bad();
        t_prefix();
        check(clash_cnt == 0, "R13 no read/write clash", clash_cnt, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule